// File: doc/BRIEF.md
# Eight-Channel Programmable Delay Pulse Generator

This block turns one shared timebase into eight independent, programmable timing pulses. A reference event (a one-cycle `fiducial` input) zeroes a 20-bit up counter, which then counts clock cycles. Each channel holds a 20-bit delay word. When the counter reaches a channel's delay, that channel drives a pulse exactly eight clocks wide. One counter serves all eight channels. Every stored word is compared against the counter value in parallel, in the manner of a content-addressable memory, so no channel has its own counter.

Each comparison is split into two fields: the upper 17 bits and the lower 3 bits. A pulse starts when the upper fields match and the counter's lower field equals the word's lower field. The lower field must be zero for this to happen. The pulse then holds for as long as the upper fields match, which gives eight cycles at the natural count rate. Software writes and reads the delay words by a 3-bit channel address. A shared output enable gates every pulse output. A registered overflow flag marks the upper quarters of each half of the count range. Two test inputs let the counter be preloaded with any value or held still.

Top module: `chan_delay_timer`

## Requirements
- R1: A write (`wr_en` high) stores `wdata` into the word selected by `addr` at the next clock edge. `rdata` always shows the word selected by the current `addr`, with no added latency.
- R2: After reset every delay word reads 20'hFFFFF, every `pulse` bit is 0, `ovf` is 0 and the counter is 0.
- R3: A clock edge that samples `fiducial` high loads the counter with 0. This takes precedence over a preload in the same cycle.
- R4: For a word whose low 3 bits are zero and whose value is D, that channel's `pulse` bit goes high on the edge after the one that leaves the counter at D. It stays high for exactly 8 consecutive cycles. After a fiducial this means the pulse is high from the (D+2)-th to the (D+9)-th falling edge, counting the falling edge that launched the fiducial as 0.
- R5: A word whose low 3 bits are nonzero never produces a pulse, even while its upper 17 bits equal those of the counter.
- R6: While `out_en` is low every `pulse` bit is 0, whatever the match state.
- R7: A clock edge that samples `preload_en` high, with no fiducial, loads `preload_val` into the counter. Otherwise the counter increments by one per edge and by default wraps from 20'hFFFFF to 0.
- R8: While `count_hold` is high, with no fiducial or preload, the counter keeps its value. A pending pulse is then delayed by one cycle for each held edge.
- R9: `ovf` is high exactly when counter bits 18 and 17 are both 1, and it updates on the same edge as the counter. It therefore rises at counter values 0x60000 and 0xE0000 and falls at 0x80000 and 0 (on wrap).
- R10: A write to a channel whose pulse is active takes part in matching from the edge after the write. A new delay that no longer matches ends the pulse early, so the pulse is still high in the cycle right after the writing edge and low in the cycle after that.
- R11: Channels are independent. Several channels, including two with the same delay, pulse in the same cycles and do not affect one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| fiducial | input | 1 | One-cycle reference event; zeroes the counter |
| wr_en | input | 1 | Delay word write strobe |
| addr | input | 3 | Channel select for write and read |
| wdata | input | 20 | Delay value to store |
| rdata | output | 20 | Delay word of the channel selected by `addr` |
| out_en | input | 1 | Shared enable for all pulse outputs |
| preload_en | input | 1 | Test: load `preload_val` into the counter |
| preload_val | input | 20 | Test: counter preload value |
| count_hold | input | 1 | Test: freeze the counter |
| pulse | output | 8 | Per-channel delayed pulse, eight clocks wide |
| ovf | output | 1 | Registered AND of counter bits 18 and 17 |

## Verification
The counter and `ovf` take a new value at the edge that samples a fiducial, preload or hold. A channel's pulse appears one edge after the counter reaches its delay, and `rdata` and the `out_en` gating act at once. The bench drives every input on a falling edge. It reads registered results on later falling edges, numbered from the falling edge that launched the stimulus, so a result due at edge D+1 is read at falling edge D+2. Combinational results are read 1 ns after the input changes. Pulse checks record the first high falling edge and the number of high falling edges for each channel, and compare both against values worked out from the requirements.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    typedef enum logic {
        CNT_WRAP     = 1'b0,
        CNT_SATURATE = 1'b1
    } cnt_mode_e;

endpackage

// File: rtl/cdt_timebase.sv
module cdt_timebase #(
    parameter int                CW   = 20,
    parameter cdt_pkg::cnt_mode_e MODE = cdt_pkg::CNT_WRAP
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fiducial,
    input  logic          preload_en,
    input  logic [CW-1:0] preload_val,
    input  logic          count_hold,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o
);

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
    localparam int            OVF_HI  = CW - 2;
    localparam int            OVF_LO  = CW - 3;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          ovf;
    } tb_state_t;

    tb_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (fiducial) begin
            s_d.cnt = '0;
        end else if (preload_en) begin
            s_d.cnt = preload_val;
        end else if (!count_hold) begin
            if (MODE == cdt_pkg::CNT_SATURATE && s_q.cnt == CNT_MAX) begin
                s_d.cnt = s_q.cnt;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
        s_d.ovf = s_d.cnt[OVF_HI] & s_d.cnt[OVF_LO];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt_o = s_q.cnt;
    assign ovf_o = s_q.ovf;

endmodule

// File: rtl/cdt_match_cell.sv
module cdt_match_cell #(
    parameter int CW = 20,
    parameter int LW = 3
) (
    input  logic [CW-1:0] word,
    input  logic [CW-1:0] cnt,
    output logic          hi_eq,
    output logic          lo_eq,
    output logic          lo_zero
);

    assign hi_eq   = (word[CW-1:LW] == cnt[CW-1:LW]);
    assign lo_eq   = (word[LW-1:0]  == cnt[LW-1:0]);
    assign lo_zero = (word[LW-1:0]  == '0);

endmodule

// File: rtl/cdt_chan_bank.sv
module cdt_chan_bank #(
    parameter int NCH = 8,
    parameter int CW  = 20,
    parameter int LW  = 3,
    parameter int AW  = $clog2(NCH)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           addr,
    input  logic [CW-1:0]           wdata,
    input  logic [CW-1:0]           cnt,
    output logic [CW-1:0]           rdata,
    output logic [NCH-1:0]          active_o,
    output logic [NCH-1:0][CW-1:0]  words_o
);

    typedef struct packed {
        logic [NCH-1:0][CW-1:0] words;
        logic [NCH-1:0]         active;
    } bank_state_t;

    bank_state_t s_d, s_q;

    logic [NCH-1:0] hi_eq;
    logic [NCH-1:0] lo_eq;
    logic [NCH-1:0] lo_zero;

    for (genvar g = 0; g < NCH; g++) begin : g_cell
        cdt_match_cell #(
            .CW (CW),
            .LW (LW)
        ) u_cell (
            .word    (s_q.words[g]),
            .cnt     (cnt),
            .hi_eq   (hi_eq[g]),
            .lo_eq   (lo_eq[g]),
            .lo_zero (lo_zero[g])
        );
    end

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            s_d.words[addr] = wdata;
        end
        for (int i = 0; i < NCH; i++) begin
            // start on full match with a zero low field, hold while upper field matches
            s_d.active[i] = hi_eq[i] && lo_zero[i] && (lo_eq[i] || s_q.active[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.words  <= '1;
            s_q.active <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata    = s_q.words[addr];
    assign active_o = s_q.active;
    assign words_o  = s_q.words;

endmodule

// File: rtl/chan_delay_timer.sv
module chan_delay_timer #(
    parameter int                 NCH  = 8,
    parameter int                 CW   = 20,
    parameter int                 LW   = 3,
    parameter cdt_pkg::cnt_mode_e MODE = cdt_pkg::CNT_WRAP,
    parameter int                 AW   = $clog2(NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fiducial,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [CW-1:0]  wdata,
    output logic [CW-1:0]  rdata,
    input  logic           out_en,
    input  logic           preload_en,
    input  logic [CW-1:0]  preload_val,
    input  logic           count_hold,
    output logic [NCH-1:0] pulse,
    output logic           ovf
);

    logic [CW-1:0]          cnt_w;
    logic [NCH-1:0]         active_w;
    logic [NCH-1:0][CW-1:0] words_w;

    cdt_timebase #(
        .CW   (CW),
        .MODE (MODE)
    ) u_timebase (
        .clk         (clk),
        .rst_n       (rst_n),
        .fiducial    (fiducial),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .count_hold  (count_hold),
        .cnt_o       (cnt_w),
        .ovf_o       (ovf)
    );

    cdt_chan_bank #(
        .NCH (NCH),
        .CW  (CW),
        .LW  (LW),
        .AW  (AW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .cnt      (cnt_w),
        .rdata    (rdata),
        .active_o (active_w),
        .words_o  (words_w)
    );

    assign pulse = active_w & {NCH{out_en}};

endmodule

// File: rtl/cdt_checker.sv
module cdt_checker #(
    parameter int NCH = 8,
    parameter int CW  = 20,
    parameter int AW  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   fiducial,
    input logic                   preload_en,
    input logic [CW-1:0]          preload_val,
    input logic                   count_hold,
    input logic                   wr_en,
    input logic [AW-1:0]          addr,
    input logic [CW-1:0]          wdata,
    input logic [CW-1:0]          cnt,
    input logic [NCH-1:0][CW-1:0] words,
    input logic                   ovf
);

    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> words[$past(addr)] == $past(wdata));

    a_r3_fiducial_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
        fiducial |=> cnt == '0);

    a_r7_preload_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (!fiducial && preload_en) |=> cnt == $past(preload_val));

    a_r8_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (!fiducial && !preload_en && count_hold) |=> $stable(cnt));

    a_r9_no_ovf_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> !ovf);

endmodule

bind chan_delay_timer cdt_checker #(
    .NCH (NCH),
    .CW  (CW),
    .AW  (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fiducial    (fiducial),
    .preload_en  (preload_en),
    .preload_val (preload_val),
    .count_hold  (count_hold),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .cnt         (cnt_w),
    .words       (words_w),
    .ovf         (ovf)
);

// File: tb/chan_delay_timer_bench.sv
`timescale 1ns/1ps
module chan_delay_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fiducial = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [19:0] wdata = '0;
    logic [19:0] rdata;
    logic        out_en = 1'b1;
    logic        preload_en = 1'b0;
    logic [19:0] preload_val = '0;
    logic        count_hold = 1'b0;
    logic [7:0]  pulse;
    logic        ovf;

    int n_chk = 0;
    int n_fail = 0;
    int first_hi [8];
    int wid [8];

    always #4 clk = ~clk;

    chan_delay_timer u_chan_delay_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .fiducial    (fiducial),
        .wr_en       (wr_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .out_en      (out_en),
        .preload_en  (preload_en),
        .preload_val (preload_val),
        .count_hold  (count_hold),
        .pulse       (pulse),
        .ovf         (ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_obs();
        for (int c = 0; c < 8; c++) begin
            first_hi[c] = -1;
            wid[c] = 0;
        end
    endtask

    task automatic observe(input int i);
        for (int c = 0; c < 8; c++) begin
            if (pulse[c]) begin
                if (first_hi[c] < 0) first_hi[c] = i;
                wid[c]++;
            end
        end
    endtask

    task automatic write_word(input int ch, input logic [19:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = ch[2:0]; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // launch fiducial at falling edge 0, observe falling edges 1..n
    task automatic fid_run(input int n);
        clear_obs();
        @(negedge clk);
        fiducial = 1'b1;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            observe(i);
            if (i == 1) fiducial = 1'b0;
        end
    endtask

    task automatic t_reset();
        for (int c = 0; c < 8; c++) begin
            addr = c[2:0];
            #1;
            chk(rdata == 20'hFFFFF, "R2 word reset", rdata, 20'hFFFFF);
        end
        chk(pulse == 8'h00, "R2 pulse reset", pulse, 0);
        chk(ovf == 1'b0, "R2 ovf reset", ovf, 0);
    endtask

    task automatic t_readback();
        for (int c = 0; c < 8; c++) write_word(c, (20'(c) << 12) | 20'h5);
        @(negedge clk);
        for (int c = 7; c >= 0; c--) begin
            addr = c[2:0];
            #1;
            chk(rdata == ((20'(c) << 12) | 20'h5), "R1 readback", rdata, (c << 12) | 5);
        end
    endtask

    task automatic t_multi();
        write_word(0, 20'd16);
        write_word(2, 20'd19);
        write_word(3, 20'd40);
        write_word(6, 20'd40);
        write_word(7, 20'd24);
        fid_run(60);
        chk(first_hi[0] == 18 && wid[0] == 8, "R4 ch0 timing", first_hi[0] * 100 + wid[0], 1808);
        chk(first_hi[7] == 26 && wid[7] == 8, "R4 ch7 timing", first_hi[7] * 100 + wid[7], 2608);
        chk(first_hi[3] == 42 && wid[3] == 8, "R11 ch3 timing", first_hi[3] * 100 + wid[3], 4208);
        chk(first_hi[6] == 42 && wid[6] == 8, "R11 ch6 same delay", first_hi[6] * 100 + wid[6], 4208);
        chk(wid[2] == 0, "R5 low bits suppress", wid[2], 0);
        chk(wid[1] == 0 && wid[4] == 0 && wid[5] == 0, "R11 idle channels", wid[1] + wid[4] + wid[5], 0);
    endtask

    task automatic t_out_en();
        out_en = 1'b0;
        fid_run(60);
        chk(wid[0] + wid[3] + wid[6] + wid[7] == 0, "R6 out_en low", wid[0] + wid[3], 0);
        out_en = 1'b1;
    endtask

    task automatic t_fid_priority();
        clear_obs();
        @(negedge clk);
        fiducial = 1'b1; preload_en = 1'b1; preload_val = 20'h40000;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            observe(i);
            if (i == 1) begin fiducial = 1'b0; preload_en = 1'b0; end
        end
        chk(first_hi[0] == 18 && wid[0] == 8, "R3 fiducial over preload", first_hi[0] * 100 + wid[0], 1808);
    endtask

    task automatic t_hold();
        clear_obs();
        @(negedge clk);
        fiducial = 1'b1;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            observe(i);
            if (i == 1) fiducial = 1'b0;
            count_hold = (i >= 3 && i < 8);
        end
        chk(first_hi[0] == 23 && wid[0] == 8, "R8 hold shifts pulse", first_hi[0] * 100 + wid[0], 2308);
    endtask

    task automatic t_preload();
        write_word(2, 20'h80000);
        clear_obs();
        @(negedge clk);
        preload_en = 1'b1; preload_val = 20'h7FFF0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk);
            observe(i);
            if (i == 1) preload_en = 1'b0;
        end
        chk(first_hi[2] == 18 && wid[2] == 8, "R7 preload then count", first_hi[2] * 100 + wid[2], 1808);
        chk(wid[0] == 0, "R7 no early match", wid[0], 0);
    endtask

    task automatic t_rewrite();
        write_word(1, 20'd32);
        clear_obs();
        @(negedge clk);
        fiducial = 1'b1;
        for (int i = 1; i <= 50; i++) begin
            @(negedge clk);
            observe(i);
            if (i == 1) fiducial = 1'b0;
            if (i == 35) begin wr_en = 1'b1; addr = 3'd1; wdata = 20'h00400; end
            if (i == 36) wr_en = 1'b0;
        end
        chk(first_hi[1] == 34 && wid[1] == 3, "R10 rewrite cuts pulse", first_hi[1] * 100 + wid[1], 3403);
    endtask

    task automatic ovf_seq(input logic [19:0] start, input bit e1, input bit e2, input bit e3, input string req);
        @(negedge clk);
        preload_en = 1'b1; preload_val = start;
        @(negedge clk);
        preload_en = 1'b0;
        chk(ovf == e1, req, ovf, e1);
        @(negedge clk);
        chk(ovf == e2, req, ovf, e2);
        @(negedge clk);
        chk(ovf == e3, req, ovf, e3);
    endtask

    task automatic t_ovf();
        ovf_seq(20'h5FFFE, 1'b0, 1'b0, 1'b1, "R9 rise at 3/8");
        ovf_seq(20'hDFFFE, 1'b0, 1'b0, 1'b1, "R9 rise at 7/8");
        ovf_seq(20'h7FFFF, 1'b1, 1'b0, 1'b0, "R9 fall at 1/2");
        ovf_seq(20'hFFFFF, 1'b1, 1'b0, 1'b0, "R9 fall at wrap");
    endtask

    task automatic t_wrap();
        write_word(5, 20'h00000);
        clear_obs();
        @(negedge clk);
        preload_en = 1'b1; preload_val = 20'hFFFFF;
        for (int i = 1; i <= 15; i++) begin
            @(negedge clk);
            observe(i);
            if (i == 1) preload_en = 1'b0;
        end
        chk(first_hi[5] == 3 && wid[5] == 8, "R7 wrap to zero", first_hi[5] * 100 + wid[5], 308);
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_multi();
        t_out_en();
        t_fid_priority();
        t_hold();
        t_preload();
        t_rewrite();
        t_ovf();
        t_wrap();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule